// File: doc/BRIEF.md
# Flash Access Guard with Debug Lock

This block sits between the bus fabric and the on-chip flash array and decides, request by request, whether an access is granted or faulted. The decision depends on a device-wide secured state and on three attributes kept for each flash segment. A segment may be execute-only, which admits instruction fetches and refuses data reads. It may be supervisor-only, which refuses every user-mode access. It may be write-protected, which refuses program and erase. The block also drives the enable of the debug port, and it accepts a 64-bit unlock key that can re-open a secured port.

Every setting comes from a nonvolatile configuration word. The block captures that word on each clock edge at which reset is held. After reset, software may add execute-only or supervisor-only restrictions to segments, but it cannot remove them. While the device is secured, a firmware-update source may do only encrypted image writes. A single wrong key attempt disables further attempts until the next reset.

Top module: `flash_guard`

## Requirements
- R1: On any rising clock edge with `rst_n` low, the secured flag, the stored key and the three per-segment masks load from the `cfg_*` inputs, the key lockout clears and `rsp_valid` goes low.
- R2: `dbg_en` is high exactly when the device is not secured, and `dbg_grant` equals `dbg_req` AND `dbg_en` in the same cycle.
- R3: A key attempt (`key_valid`) whose `key_value` equals the stored key clears the secured state from the next cycle, provided the device is secured and not locked out.
- R4: A key attempt that does not match while the device is secured and not locked out sets `key_locked` from the next cycle. Once `key_locked` is set, later attempts leave the state unchanged until reset. Attempts made while unsecured have no effect.
- R5: The segment index is `req_addr[ADDR_W-1:SEG_LOG2]`, so each segment spans 2^SEG_LOG2 addresses.
- R6: On an execute-only segment, a fetch (`req_kind`=1) is granted and a data read (`req_kind`=0) faults with code 1.
- R7: On a supervisor-only segment, any access with `req_priv`=0 faults with code 2. With `req_priv`=1 the access passes this check.
- R8: On a write-protected segment, a write (`req_kind`=2) or an erase (`req_kind`=3) faults with code 3, and reads and fetches pass this check.
- R9: While secured, a request with `req_upd`=1 faults with code 4 unless it is a write with `req_enc`=1. While unsecured, `req_upd` has no effect.
- R10: `attr_set_en` ORs `attr_set_xo` and `attr_set_sv` into the masks, and the change applies to requests from the next cycle. No input can clear a mask bit before reset.
- R11: Each cycle with `req_valid` high produces, one cycle later, `rsp_valid`=1 with exactly one of `rsp_grant` and `rsp_fault` set, and `rsp_code`=0 on a grant. Cycles without a request give `rsp_valid`=0 with grant, fault and code all zero.
- R12: When several checks fail at once, the code reported follows the order update (4), supervisor (2), execute-only (1), write-protect (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_secure | input | 1 | Configured secured state |
| cfg_key | input | 64 | Configured unlock key |
| cfg_xo | input | SEG_CNT | Configured execute-only mask, one bit per segment |
| cfg_sv | input | SEG_CNT | Configured supervisor-only mask |
| cfg_wp | input | SEG_CNT | Configured write/erase protection mask |
| attr_set_en | input | 1 | Strobe to add restrictions |
| attr_set_xo | input | SEG_CNT | Segments to make execute-only |
| attr_set_sv | input | SEG_CNT | Segments to make supervisor-only |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Flash byte address |
| req_kind | input | 2 | 0 read, 1 fetch, 2 write, 3 erase |
| req_priv | input | 1 | 1 supervisor, 0 user |
| req_upd | input | 1 | Request comes from the firmware-update source |
| req_enc | input | 1 | Request carries an encrypted image write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 1 | Access refused |
| rsp_code | output | 3 | 0 none, 1 execute-only, 2 supervisor, 3 protected, 4 update source |
| key_valid | input | 1 | Unlock key attempt |
| key_value | input | 64 | Presented key |
| key_locked | output | 1 | Further key attempts disabled until reset |
| dbg_req | input | 1 | Debug port access request |
| dbg_en | output | 1 | Debug port enabled |
| dbg_grant | output | 1 | Debug request granted |

## Verification
The assertions check, on every cycle, that a fault follows each read of an execute-only segment, each user access to a supervisor-only segment, each write or erase of a protected segment, and each forbidden update-source request while secured. They also check that a response always carries exactly one of grant and fault, that mask bits and the key lockout never clear before reset, and that a locked-out device stays secured. The bench scenarios are the only place that shows which fault code wins when several checks apply, that the segment index changes exactly at a 2^SEG_LOG2 boundary, that a new restriction first affects the request in the following cycle, and that debug access re-opens after a correct key and after a reset with different configuration.

// File: rtl/fg_pkg.sv
// Shared types for the flash access guard.
// Assumes: request kinds and fault codes keep the numeric values below,
// since they are visible at the top-level ports.
package fg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_FETCH = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_ERASE = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_XONLY  = 3'd1,
        FLT_SUPV   = 3'd2,
        FLT_WPROT  = 3'd3,
        FLT_UPDATE = 3'd4
    } flt_code_e;

    typedef struct packed {
        logic xo;
        logic sv;
        logic wp;
    } seg_attr_t;

endpackage

// File: rtl/fg_sec_state.sv
// Secured-state and unlock-key tracker.
// Holds the secured flag and the stored key, both taken from configuration
// while reset is held. One matching attempt unsecures the device; one
// mismatching attempt locks out all further attempts until reset.
// Assumes: attempts made while unsecured are ignored.
module fg_sec_state #(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_secure,
    input  logic [KEY_W-1:0] cfg_key,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_value,
    output logic             secured,
    output logic             locked
);

    logic [KEY_W-1:0] key_q;
    logic             attempt;
    logic             match;

    // An attempt counts only while secured and not yet locked out
    always_comb begin
        attempt = key_valid && secured && !locked;
        match   = (key_value == key_q);
    end

    // Capture configuration at reset, then apply key attempts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secured <= cfg_secure;
            key_q   <= cfg_key;
            locked  <= 1'b0;
        end else if (attempt) begin
            if (match) begin
                secured <= 1'b0;
            end else begin
                locked  <= 1'b1;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R4

    AST_LOCK_HOLDS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && secured) |=> secured); // R4

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && secured && !locked && (key_value != key_q)) |=> locked); // R4

    AST_GOOD_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && secured && !locked && (key_value == key_q)) |=> !secured); // R3

endmodule

// File: rtl/fg_seg_attr.sv
// Per-segment attribute store.
// Three masks of SEG_CNT bits: execute-only, supervisor-only and write
// protect. All three load from configuration while reset is held.
// Software may set execute-only and supervisor-only bits afterwards, but
// never clear them. Write protect is fixed between resets.
// Assumes: seg_idx is already range-limited by its width.
module fg_seg_attr
    import fg_pkg::*;
#(
    parameter int SEG_CNT = 64,
    localparam int IDX_W  = $clog2(SEG_CNT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEG_CNT-1:0] cfg_xo,
    input  logic [SEG_CNT-1:0] cfg_sv,
    input  logic [SEG_CNT-1:0] cfg_wp,
    input  logic               set_en,
    input  logic [SEG_CNT-1:0] set_xo,
    input  logic [SEG_CNT-1:0] set_sv,
    input  logic [IDX_W-1:0]   seg_idx,
    output seg_attr_t          attr
);

    logic [SEG_CNT-1:0] xo_q;
    logic [SEG_CNT-1:0] sv_q;
    logic [SEG_CNT-1:0] wp_q;

    // Load at reset; afterwards restrictions can only be added
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xo_q <= cfg_xo;
            sv_q <= cfg_sv;
            wp_q <= cfg_wp;
        end else if (set_en) begin
            xo_q <= xo_q | set_xo;
            sv_q <= sv_q | set_sv;
        end
    end

    // Select the attributes of the addressed segment
    always_comb begin
        attr.xo = xo_q[seg_idx];
        attr.sv = sv_q[seg_idx];
        attr.wp = wp_q[seg_idx];
    end

    AST_XO_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(xo_q) & ~xo_q) == '0)); // R10

    AST_SV_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(sv_q) & ~sv_q) == '0)); // R10

    AST_WP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(wp_q)); // R8

endmodule

// File: rtl/fg_access_check.sv
// Access decision and registered response.
// Evaluates one request per cycle against the secured state and the
// addressed segment's attributes, and reports grant or fault one cycle later.
// Assumes: the attribute and secured inputs are register outputs that are
// stable for the whole cycle.
module fg_access_check
    import fg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  acc_kind_e req_kind,
    input  logic      req_priv,
    input  logic      req_upd,
    input  logic      req_enc,
    input  logic      secured,
    input  seg_attr_t attr,
    output logic      rsp_valid,
    output logic      rsp_grant,
    output logic      rsp_fault,
    output flt_code_e rsp_code
);

    flt_code_e code_d;
    logic      is_mod;
    logic      upd_ok;

    // Pick the fault code, highest-priority check first
    always_comb begin
        is_mod = (req_kind == ACC_WRITE) || (req_kind == ACC_ERASE);
        upd_ok = (req_kind == ACC_WRITE) && req_enc;
        if (secured && req_upd && !upd_ok) begin
            code_d = FLT_UPDATE;
        end else if (!req_priv && attr.sv) begin
            code_d = FLT_SUPV;
        end else if ((req_kind == ACC_READ) && attr.xo) begin
            code_d = FLT_XONLY;
        end else if (is_mod && attr.wp) begin
            code_d = FLT_WPROT;
        end else begin
            code_d = FLT_NONE;
        end
    end

    // Register the response for the request of this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= FLT_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && (code_d == FLT_NONE);
            rsp_fault <= req_valid && (code_d != FLT_NONE);
            rsp_code  <= req_valid ? code_d : FLT_NONE;
        end
    end

    AST_XO_READ_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == ACC_READ) && attr.xo) |=> rsp_fault); // R6

    AST_USER_SV_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && attr.sv) |=> rsp_fault); // R7

    AST_WP_MOD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_kind == ACC_WRITE) || (req_kind == ACC_ERASE)) && attr.wp)
        |=> (rsp_fault && (rsp_code != FLT_NONE))); // R8

    AST_UPD_SECURED_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && secured && req_upd && !((req_kind == ACC_WRITE) && req_enc))
        |=> (rsp_fault && (rsp_code == FLT_UPDATE))); // R9

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && (rsp_grant != rsp_fault))); // R11

    AST_RSP_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_fault && (rsp_code == FLT_NONE))); // R11

endmodule

// File: rtl/flash_guard.sv
// Flash access guard with debug lock (top level).
// Splits the address into a segment index, looks up that segment's
// attributes, decides grant or fault, and drives the debug enable from the
// secured state. Configuration is captured on every clock edge with rst_n low.
// Assumes: SEG_LOG2 < ADDR_W and at most a few thousand segments.
module flash_guard
    import fg_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int SEG_LOG2 = 12,
    parameter int KEY_W    = 64,
    localparam int IDX_W   = ADDR_W - SEG_LOG2,
    localparam int SEG_CNT = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_secure,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [SEG_CNT-1:0] cfg_xo,
    input  logic [SEG_CNT-1:0] cfg_sv,
    input  logic [SEG_CNT-1:0] cfg_wp,
    input  logic               attr_set_en,
    input  logic [SEG_CNT-1:0] attr_set_xo,
    input  logic [SEG_CNT-1:0] attr_set_sv,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_kind,
    input  logic               req_priv,
    input  logic               req_upd,
    input  logic               req_enc,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic               rsp_fault,
    output logic [2:0]         rsp_code,
    input  logic               key_valid,
    input  logic [KEY_W-1:0]   key_value,
    output logic               key_locked,
    input  logic               dbg_req,
    output logic               dbg_en,
    output logic               dbg_grant
);

    logic [IDX_W-1:0] seg_idx;
    logic             unused_low;
    logic             secured;
    seg_attr_t        attr;
    flt_code_e        code_q;

    // Segment index from the upper address bits; the offset is not needed
    always_comb begin
        seg_idx    = req_addr[ADDR_W-1:SEG_LOG2];
        unused_low = ^req_addr[SEG_LOG2-1:0];
    end

    fg_sec_state #(
        .KEY_W (KEY_W)
    ) i_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_secure (cfg_secure),
        .cfg_key    (cfg_key),
        .key_valid  (key_valid),
        .key_value  (key_value),
        .secured    (secured),
        .locked     (key_locked)
    );

    fg_seg_attr #(
        .SEG_CNT (SEG_CNT)
    ) i_attr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_xo  (cfg_xo),
        .cfg_sv  (cfg_sv),
        .cfg_wp  (cfg_wp),
        .set_en  (attr_set_en),
        .set_xo  (attr_set_xo),
        .set_sv  (attr_set_sv),
        .seg_idx (seg_idx),
        .attr    (attr)
    );

    fg_access_check i_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (acc_kind_e'(req_kind)),
        .req_priv  (req_priv),
        .req_upd   (req_upd),
        .req_enc   (req_enc),
        .secured   (secured),
        .attr      (attr),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_fault (rsp_fault),
        .rsp_code  (code_q)
    );

    // Debug port follows the secured state; response code to a plain vector
    always_comb begin
        dbg_en    = !secured;
        dbg_grant = dbg_req && dbg_en;
        rsp_code  = code_q;
    end

    AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && key_locked && !dbg_en) |=> !dbg_grant); // R2

endmodule

// File: tb/test_flash_guard.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module test_flash_guard;

    localparam int ADDR_W   = 18;
    localparam int SEG_LOG2 = 12;
    localparam int NSEG     = 1 << (ADDR_W - SEG_LOG2);
    localparam logic [63:0] KEY_A = 64'hA5C3_1E77_0D9B_4F62;
    localparam logic [63:0] KEY_B = 64'h3C0F_9912_E4D7_6B08;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_secure = 1'b1;
    logic [63:0]       cfg_key = KEY_A;
    logic [NSEG-1:0]   cfg_xo = '0, cfg_sv = '0, cfg_wp = '0;
    logic              attr_set_en = 1'b0;
    logic [NSEG-1:0]   attr_set_xo = '0, attr_set_sv = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_kind = 2'd0;
    logic              req_priv = 1'b0, req_upd = 1'b0, req_enc = 1'b0;
    logic              key_valid = 1'b0;
    logic [63:0]       key_value = '0;
    logic              dbg_req = 1'b0;
    logic              rsp_valid, rsp_grant, rsp_fault, key_locked, dbg_en, dbg_grant;
    logic [2:0]        rsp_code;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit       m_sec, m_lock;
    bit [63:0] m_key;
    bit       m_xo[NSEG], m_sv[NSEG], m_wp[NSEG];
    bit       m_rv, m_rg, m_rf;
    int       m_rc;

    flash_guard #(.ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2)) i_flash_guard (
        .clk(clk), .rst_n(rst_n), .cfg_secure(cfg_secure), .cfg_key(cfg_key),
        .cfg_xo(cfg_xo), .cfg_sv(cfg_sv), .cfg_wp(cfg_wp),
        .attr_set_en(attr_set_en), .attr_set_xo(attr_set_xo), .attr_set_sv(attr_set_sv),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_priv(req_priv), .req_upd(req_upd), .req_enc(req_enc),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .key_valid(key_valid), .key_value(key_value),
        .key_locked(key_locked), .dbg_req(dbg_req), .dbg_en(dbg_en), .dbg_grant(dbg_grant)
    );

    always #5 clk = ~clk;

    // Reference model: advances on each rising edge from the applied inputs
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_sec  = cfg_secure;
            m_lock = 1'b0;
            m_key  = cfg_key;
            for (int i = 0; i < NSEG; i++) begin
                m_xo[i] = cfg_xo[i];
                m_sv[i] = cfg_sv[i];
                m_wp[i] = cfg_wp[i];
            end
            m_rv = 0; m_rg = 0; m_rf = 0; m_rc = 0;
        end else begin
            m_rv = req_valid; m_rg = 0; m_rf = 0; m_rc = 0;
            if (req_valid) begin
                int seg;
                int code;
                seg  = int'(req_addr) / (1 << SEG_LOG2);
                code = 0;
                if (m_sec && req_upd && !(req_kind == 2 && req_enc)) code = 4;
                else if (!req_priv && m_sv[seg]) code = 2;
                else if (req_kind == 0 && m_xo[seg]) code = 1;
                else if ((req_kind == 2 || req_kind == 3) && m_wp[seg]) code = 3;
                m_rc = code;
                m_rg = (code == 0);
                m_rf = (code != 0);
            end
            if (attr_set_en) begin
                for (int i = 0; i < NSEG; i++) begin
                    if (attr_set_xo[i]) m_xo[i] = 1'b1;
                    if (attr_set_sv[i]) m_sv[i] = 1'b1;
                end
            end
            if (key_valid && m_sec && !m_lock) begin
                if (key_value == m_key) m_sec = 1'b0;
                else m_lock = 1'b1;
            end
        end
    end

    // Compare every output with the model midway through each cycle
    always @(negedge clk) begin
        if (started && !done) begin
            bit exp_dbg_en, exp_dbg_grant;
            exp_dbg_en    = !m_sec;
            exp_dbg_grant = dbg_req && !m_sec;
            total++;
            if (rsp_valid !== m_rv || rsp_grant !== m_rg || rsp_fault !== m_rf ||
                int'(rsp_code) != m_rc || dbg_en !== exp_dbg_en ||
                dbg_grant !== exp_dbg_grant || key_locked !== m_lock) begin
                bad++;
                $display("FAIL %s t=%0t: got v=%b g=%b f=%b c=%0d den=%b dg=%b lk=%b exp v=%b g=%b f=%b c=%0d den=%b dg=%b lk=%b",
                         cur_req, $time, rsp_valid, rsp_grant, rsp_fault, rsp_code,
                         dbg_en, dbg_grant, key_locked, m_rv, m_rg, m_rf, m_rc,
                         exp_dbg_en, exp_dbg_grant, m_lock);
            end
        end
    end

    task automatic idle_inputs();
        req_valid = 0; req_upd = 0; req_enc = 0; req_priv = 0;
        attr_set_en = 0; attr_set_xo = '0; attr_set_sv = '0;
        key_valid = 0; dbg_req = 0;
    endtask

    task automatic next_cycle(input string tag);
        @(negedge clk); #1;
        idle_inputs();
        cur_req = tag;
    endtask

    task automatic do_req(input string tag, input int kind, input int seg, input int off,
                          input bit priv, input bit upd, input bit enc);
        next_cycle(tag);
        req_valid = 1;
        req_kind  = 2'(kind);
        req_addr  = ADDR_W'(seg * (1 << SEG_LOG2) + off);
        req_priv  = priv;
        req_upd   = upd;
        req_enc   = enc;
    endtask

    task automatic do_reset(input bit secure);
        next_cycle("R1");
        rst_n = 0;
        cfg_secure = secure;
        cfg_key = KEY_A;
        cfg_xo = '0; cfg_sv = '0; cfg_wp = '0;
        cfg_xo[2] = 1; cfg_xo[9] = 1;
        cfg_sv[5] = 1; cfg_sv[9] = 1;
        cfg_wp[7] = 1; cfg_wp[63] = 1;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        do_reset(1'b1);
        next_cycle("R1");                     // reset state: secured, no response
        next_cycle("R2"); dbg_req = 1;        // debug refused while secured
        // R5 boundary: last byte of segment 1, first byte of segment 2
        do_req("R5", 0, 1, (1 << SEG_LOG2) - 1, 1, 0, 0);
        do_req("R5", 0, 2, 0, 1, 0, 0);
        // R6 execute-only segment 2
        do_req("R6", 1, 2, 16, 0, 0, 0);
        do_req("R6", 0, 2, 16, 0, 0, 0);
        // R7 supervisor-only segment 5
        do_req("R7", 1, 5, 4, 0, 0, 0);
        do_req("R7", 2, 5, 4, 0, 0, 0);
        do_req("R7", 0, 5, 4, 1, 0, 0);
        // R8 protected segments 7 and 63
        do_req("R8", 2, 7, 0, 1, 0, 0);
        do_req("R8", 3, 63, 8, 1, 0, 0);
        do_req("R8", 0, 7, 0, 1, 0, 0);
        do_req("R8", 2, 6, 0, 1, 0, 0);
        next_cycle("R11");                    // gap: rsp quiet
        next_cycle("R11");
        // R9 update source while secured
        do_req("R9", 0, 0, 0, 1, 1, 0);
        do_req("R9", 2, 0, 0, 1, 1, 0);
        do_req("R9", 2, 0, 0, 1, 1, 1);
        do_req("R9", 3, 0, 0, 1, 1, 1);
        do_req("R9", 2, 7, 0, 1, 1, 1);
        // R12 priorities
        do_req("R12", 0, 9, 0, 0, 0, 0);      // sv and xo: 2
        do_req("R12", 0, 9, 0, 0, 1, 0);      // update wins: 4
        do_req("R12", 0, 9, 0, 1, 0, 0);      // supervisor: xo 1
        do_req("R12", 2, 2, 0, 0, 0, 0);      // xo segment write, then wp: none
        // R10 add restriction to segment 0, try to clear segment 2
        next_cycle("R10");
        attr_set_en = 1; attr_set_xo[0] = 1; attr_set_sv[3] = 1;
        req_valid = 1; req_kind = 0; req_addr = '0; req_priv = 1;  // same cycle: old attrs
        do_req("R10", 0, 0, 0, 1, 0, 0);
        do_req("R10", 1, 0, 0, 1, 0, 0);
        do_req("R10", 1, 3, 0, 0, 0, 0);
        next_cycle("R10");
        attr_set_en = 1;                      // zero masks clear nothing
        do_req("R10", 0, 2, 0, 1, 0, 0);
        do_req("R10", 0, 0, 0, 1, 0, 0);
        // R4 wrong key locks out, then correct key ignored
        next_cycle("R4"); key_valid = 1; key_value = KEY_B;
        next_cycle("R4"); key_valid = 1; key_value = KEY_A;
        next_cycle("R4"); dbg_req = 1;
        next_cycle("R4");
        // R1 reset clears lockout and restores masks
        do_reset(1'b1);
        next_cycle("R1");
        do_req("R1", 1, 0, 0, 1, 0, 0);
        // R3 correct key opens debug
        next_cycle("R3"); key_valid = 1; key_value = KEY_A; dbg_req = 1;
        next_cycle("R3"); dbg_req = 1;
        next_cycle("R2"); dbg_req = 1;
        // R4 attempts while unsecured have no effect
        next_cycle("R4"); key_valid = 1; key_value = KEY_B;
        next_cycle("R4");
        // R9 update source unrestricted when unsecured
        do_req("R9", 0, 0, 0, 1, 1, 0);
        do_req("R9", 2, 1, 0, 1, 1, 0);
        // back-to-back requests
        do_req("R11", 1, 2, 0, 0, 0, 0);
        do_req("R11", 3, 7, 0, 1, 0, 0);
        do_req("R11", 0, 10, 0, 0, 0, 0);
        // reset unsecured
        do_reset(1'b0);
        next_cycle("R2"); dbg_req = 1;
        next_cycle("R2");
        next_cycle("R2");
        @(negedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule